// File: doc/BRIEF.md
# Register-mapped UART with pin relocation

This block is a byte-wide serial port that a processor core reaches through three 32-bit registers: a combined transmit/status register, a receive register and a bit-rate divisor. A write to the transmit register launches one frame on the transmit line. Reads report state through whole-word sentinels instead of flag bits. The status register reads all ones while a frame is being sent and zero once the line is free. The receive register reads all ones when nothing has arrived, and reading it consumes the byte.

Every bit on the line lasts divisor + 1 core clocks. A frame has one low start bit, eight data bits sent least significant first and one high stop bit. The line idles high. The receiver passes its input through a synchroniser and acts only on a falling edge. It confirms the start bit halfway through the bit time, samples each data bit at its centre and keeps a single byte until software collects it.

A relocation control lets the port use a second pair of pads. While it is set, the transmit waveform also appears on the alternate output and the receiver listens to the alternate input instead of the default one.

Top module: `mmio_uart`

## Requirements
- R1: After reset the default transmit output is high, the status register reads 0x00000000, the receive register reads 0xFFFFFFFF and the divisor reads 88 (0x00000058).
- R2: The status register (select 0) reads 0xFFFFFFFF from the clock edge that accepts a transmit write until the frame ends, which is exactly 10 x (divisor + 1) cycles later. At all other times it reads 0x00000000.
- R3: A write to select 0 sends bits [7:0] of the written word. The frame is one low start bit, then data bits 0 to 7 in that order, then one high stop bit. Each bit lasts divisor + 1 cycles, and the line is high whenever no frame is in progress.
- R4: A write to select 0 while a frame is in progress is ignored. The current frame continues unchanged and no second frame follows.
- R5: A write to the divisor register (select 2) stores bits [15:0]. Reading it returns that value zero-extended to 32 bits.
- R6: Reading the receive register (select 1) returns the held byte zero-extended to 32 bits, or 0xFFFFFFFF when no byte is held.
- R7: A read of the receive register empties it, so the next read returns 0xFFFFFFFF. Reads of other registers leave the held byte in place.
- R8: A byte that completes while a previous one is still held replaces it.
- R9: A frame whose stop bit is low is discarded, and the held state does not change.
- R10: A low pulse on the receive input that has ended by the middle of a start bit does not produce a byte.
- R11: With relocation set, the alternate output carries the same waveform as the default output, and only the alternate input feeds the receiver. With relocation clear, the alternate output stays high and only the default input feeds the receiver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 2 | Register select: 0 transmit/status, 1 receive, 2 divisor, 3 unused (reads zero) |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; a read of select 1 consumes the byte |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for the selected register, valid in the same cycle |
| relocEn | input | 1 | Relocation control for the serial pads |
| rxdMain | input | 1 | Default receive pad |
| rxdAlt | input | 1 | Alternate receive pad |
| txdMain | output | 1 | Default transmit pad |
| txdAlt | output | 1 | Alternate transmit pad |

## Verification
The receive corner cases are the hardest to reach from the ports. A discarded frame with a low stop bit, a start pulse too short to pass the mid-bit check, and a byte that arrives while the buffer is still full all need the bench to act as a bit-accurate serial transmitter. The bench does this with a task that holds each line level for exactly divisor + 1 cycles and can force a bad stop bit. Single-cycle glitches are driven directly on the pad. The transmit side is swept over all 256 byte values at a small divisor. Line samples are taken at computed bit centres, and the busy status is probed on the last busy cycle and the first idle cycle.

// File: rtl/uart_pkg.sv
package uart_pkg;
  localparam int REG_W   = 32;
  localparam int DATA_W  = 8;
  localparam int DIV_W   = 16;
  localparam int FRAME_W = DATA_W + 2;

  typedef enum logic [1:0] {
    SEL_TXSTAT  = 2'd0,
    SEL_RXDATA  = 2'd1,
    SEL_DIVISOR = 2'd2,
    SEL_NONE    = 2'd3
  } regSel_e;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rxState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic              txStart;
    logic [DATA_W-1:0] txByte;
    logic              divLoad;
    logic [DIV_W-1:0]  divValue;
    logic              rxPop;
  } ctrlStrobe_t;

  // datapath -> control state
  typedef struct packed {
    logic              txBusy;
    logic              rxFull;
    logic [DATA_W-1:0] rxByte;
    logic [DIV_W-1:0]  divisor;
  } dpStatus_t;
endpackage

// File: rtl/uart_ctrl.sv
module uart_ctrl
  import uart_pkg::*;
(
  input  logic [1:0]       regSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [REG_W-1:0] wrData,
  input  dpStatus_t        status,
  output ctrlStrobe_t      strobe,
  output logic [REG_W-1:0] rdData
);
  regSel_e sel;
  logic    unusedWrHi;

  assign sel        = regSel_e'(regSel);
  assign unusedWrHi = ^wrData[REG_W-1:DIV_W];

  always_comb begin
    strobe          = '0;
    strobe.txByte   = wrData[DATA_W-1:0];
    strobe.divValue = wrData[DIV_W-1:0];
    // a transmit write during a frame is dropped
    strobe.txStart  = wrEn && (sel == SEL_TXSTAT) && !status.txBusy;
    strobe.divLoad  = wrEn && (sel == SEL_DIVISOR);
    strobe.rxPop    = rdEn && (sel == SEL_RXDATA);
  end

  always_comb begin
    unique case (sel)
      SEL_TXSTAT:  rdData = status.txBusy ? '1 : '0;
      SEL_RXDATA:  rdData = status.rxFull ? {{(REG_W-DATA_W){1'b0}}, status.rxByte} : '1;
      SEL_DIVISOR: rdData = {{(REG_W-DIV_W){1'b0}}, status.divisor};
      default:     rdData = '0;
    endcase
  end
endmodule

// File: rtl/uart_dpath.sv
module uart_dpath
  import uart_pkg::*;
#(
  parameter int                     SYNC_STAGES = 2,
  parameter logic [uart_pkg::DIV_W-1:0] DIV_RESET = 16'd88
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t strobe,
  input  logic        rxdIn,
  output logic        txLine,
  output dpStatus_t   status
);
  localparam int TX_IDX_W = $clog2(FRAME_W);
  localparam int RX_IDX_W = $clog2(DATA_W);
  localparam logic [TX_IDX_W-1:0] TX_LAST = TX_IDX_W'(FRAME_W - 1);
  localparam logic [RX_IDX_W-1:0] RX_LAST = RX_IDX_W'(DATA_W - 1);

  // ---------------- divisor ----------------
  logic [DIV_W-1:0] divReg;
  always_ff @(posedge clk) begin
    if (!rstN)               divReg <= DIV_RESET;
    else if (strobe.divLoad) divReg <= strobe.divValue;
  end

  // ---------------- transmitter ----------------
  logic                txBusy;
  logic [DIV_W-1:0]    txCnt;
  logic [DIV_W-1:0]    txDiv;
  logic [TX_IDX_W-1:0] txIdx;
  logic [FRAME_W-1:0]  txShift;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txCnt   <= '0;
      txDiv   <= '0;
      txIdx   <= '0;
      txShift <= '1;
    end else if (strobe.txStart) begin
      txBusy  <= 1'b1;
      txCnt   <= '0;
      txDiv   <= divReg;
      txIdx   <= '0;
      txShift <= {1'b1, strobe.txByte, 1'b0};
    end else if (txBusy) begin
      if (txCnt == txDiv) begin
        txCnt   <= '0;
        txShift <= {1'b1, txShift[FRAME_W-1:1]};
        if (txIdx == TX_LAST) txBusy <= 1'b0;
        else                  txIdx  <= txIdx + 1'b1;
      end else begin
        txCnt <= txCnt + 1'b1;
      end
    end
  end

  assign txLine = txBusy ? txShift[0] : 1'b1;

  // ---------------- receive synchroniser ----------------
  logic [SYNC_STAGES-1:0] syncQ;
  logic                   rxS;
  logic                   rxPrev;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= rxdIn;
      end
    end else begin : g_syncN
      always_ff @(posedge clk) begin
        if (!rstN) syncQ <= '1;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], rxdIn};
      end
    end
  endgenerate

  assign rxS = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) rxPrev <= 1'b1;
    else       rxPrev <= rxS;
  end

  // ---------------- receiver ----------------
  rxState_e            rxState;
  logic [DIV_W-1:0]    rxCnt;
  logic [DIV_W-1:0]    rxDiv;
  logic [RX_IDX_W-1:0] rxIdx;
  logic [DATA_W-1:0]   rxShift;
  logic [DATA_W-1:0]   rxBuf;
  logic                rxFull;
  logic                rxFallEdge;
  logic                rxCntAtHalf;
  logic                rxCntAtEnd;
  logic                rxLoad;

  assign rxFallEdge  = rxPrev && !rxS;
  assign rxCntAtHalf = (rxCnt == (rxDiv >> 1));
  assign rxCntAtEnd  = (rxCnt == rxDiv);
  assign rxLoad      = (rxState == RX_STOP) && rxCntAtEnd && rxS;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxState <= RX_IDLE;
      rxCnt   <= '0;
      rxDiv   <= '0;
      rxIdx   <= '0;
      rxShift <= '0;
    end else begin
      unique case (rxState)
        RX_IDLE: begin
          if (rxFallEdge) begin
            rxState <= RX_START;
            rxCnt   <= '0;
            rxDiv   <= divReg;
          end
        end
        RX_START: begin
          if (rxCntAtHalf) begin
            rxCnt   <= '0;
            rxIdx   <= '0;
            rxState <= rxS ? RX_IDLE : RX_DATA;
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
        RX_DATA: begin
          if (rxCntAtEnd) begin
            rxCnt   <= '0;
            rxShift <= {rxS, rxShift[DATA_W-1:1]};
            if (rxIdx == RX_LAST) rxState <= RX_STOP;
            else                  rxIdx   <= rxIdx + 1'b1;
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
        RX_STOP: begin
          if (rxCntAtEnd) begin
            rxCnt   <= '0;
            rxState <= RX_IDLE;
          end else begin
            rxCnt <= rxCnt + 1'b1;
          end
        end
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBuf  <= '0;
      rxFull <= 1'b0;
    end else if (rxLoad) begin
      rxBuf  <= rxShift;
      rxFull <= 1'b1;
    end else if (strobe.rxPop) begin
      rxFull <= 1'b0;
    end
  end

  assign status.txBusy  = txBusy;
  assign status.rxFull  = rxFull;
  assign status.rxByte  = rxBuf;
  assign status.divisor = divReg;
endmodule

// File: rtl/mmio_uart.sv
module mmio_uart
  import uart_pkg::*;
#(
  parameter int                     SYNC_STAGES = 2,
  parameter logic [uart_pkg::DIV_W-1:0] DIV_RESET = 16'd88
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  regSel,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  input  logic        relocEn,
  input  logic        rxdMain,
  input  logic        rxdAlt,
  output logic        txdMain,
  output logic        txdAlt
);
  ctrlStrobe_t strobe;
  dpStatus_t   dpStat;
  logic        txLine;
  logic        rxdPick;

  assign rxdPick = relocEn ? rxdAlt : rxdMain;
  assign txdMain = txLine;
  assign txdAlt  = relocEn ? txLine : 1'b1;

  uart_ctrl u_ctrl (
    .regSel (regSel),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .wrData (wrData),
    .status (dpStat),
    .strobe (strobe),
    .rdData (rdData)
  );

  uart_dpath #(
    .SYNC_STAGES (SYNC_STAGES),
    .DIV_RESET   (DIV_RESET)
  ) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .rxdIn  (rxdPick),
    .txLine (txLine),
    .status (dpStat)
  );
endmodule

// File: rtl/uart_checker.sv
module uart_checker
  import uart_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  regSel,
  input logic        wrEn,
  input logic        rdEn,
  input logic [15:0] divWrData,
  input logic [31:0] rdData,
  input logic        relocEn,
  input logic        txdMain,
  input logic        txdAlt,
  input dpStatus_t   stat
);
  AST_BUSY_FROM_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat.txBusy) |-> $past(wrEn && regSel == 2'd0)); // R3

  AST_START_BIT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(stat.txBusy) |-> !txdMain); // R3

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    !stat.txBusy |-> txdMain); // R3

  AST_STATUS_SENTINEL: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'd0) |-> (rdData == (stat.txBusy ? 32'hFFFF_FFFF : 32'h0))); // R2

  AST_RX_EMPTY_SENTINEL: assert property (@(posedge clk) disable iff (!rstN)
    (regSel == 2'd1 && !stat.rxFull) |-> (rdData == 32'hFFFF_FFFF)); // R6

  AST_POP_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    $fell(stat.rxFull) |-> $past(rdEn && regSel == 2'd1)); // R7

  AST_DIV_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 2'd2) |=> (stat.divisor == $past(divWrData))); // R5

  AST_ALT_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    relocEn |-> (txdAlt == txdMain)); // R11

  AST_ALT_PARKED: assert property (@(posedge clk) disable iff (!rstN)
    !relocEn |-> txdAlt); // R11
endmodule

bind mmio_uart uart_checker u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regSel    (regSel),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .divWrData (wrData[15:0]),
  .rdData    (rdData),
  .relocEn   (relocEn),
  .txdMain   (txdMain),
  .txdAlt    (txdAlt),
  .stat      (dpStat)
);

// File: tb/tb_mmio_uart.sv
module tb_mmio_uart;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = 2'd3;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        relocEn = 1'b0;
  logic        rxdMain = 1'b1;
  logic        rxdAlt = 1'b1;
  logic        txdMain;
  logic        txdAlt;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  mmio_uart dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .relocEn(relocEn),
    .rxdMain(rxdMain), .rxdAlt(rxdAlt), .txdMain(txdMain), .txdAlt(txdAlt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    regSel = sel; wrData = data; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    regSel = sel; rdEn = 1'b1;
    #1 val = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peek(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    regSel = sel; rdEn = 1'b0;
    #1 val = rdData;
  endtask

  // transmit one byte and check the line at every bit centre
  task automatic txFrame(input logic [7:0] b, input int d, input bit midWrite);
    logic [9:0] expBits, gotMain, gotAlt;
    bit busyOk;
    int h;
    h = (d + 1) / 2;
    expBits = {1'b1, b, 1'b0};
    busyOk = 1'b1;
    regWrite(2'd0, {24'hA5C3E1, b});
    regSel = 2'd0;
    repeat (h) @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      #1;
      gotMain[k] = txdMain;
      gotAlt[k]  = txdAlt;
      if (rdData !== 32'hFFFF_FFFF) busyOk = 1'b0;
      if (k < 9) begin
        if (midWrite && k == 4) begin
          wrData = {24'h0, ~b}; wrEn = 1'b1;
          @(negedge clk);
          wrEn = 1'b0;
          repeat (d) @(negedge clk);
        end else begin
          repeat (d + 1) @(negedge clk);
        end
      end
    end
    chk("R3 frame on default pad", {22'h0, gotMain}, {22'h0, expBits});
    chk("R11 alternate pad", {22'h0, gotAlt}, {22'h0, (relocEn ? expBits : 10'h3FF)});
    chk("R2 busy during frame", {31'h0, busyOk}, 32'h1);
    repeat (d - h) @(negedge clk);
    #1 chk("R2 last busy cycle", rdData, 32'hFFFF_FFFF);
    @(negedge clk);
    #1 chk("R2 idle after frame", rdData, 32'h0);
    if (midWrite) begin
      repeat (d + 1) @(negedge clk);
      #1 chk("R4 no second frame", {30'h0, txdMain, rdData[0]}, {30'h0, 1'b1, 1'b0});
    end
  endtask

  task automatic setRx(input bit useAlt, input logic v);
    if (useAlt) rxdAlt = v; else rxdMain = v;
  endtask

  // drive one serial frame on a receive pad
  task automatic rxSend(input logic [7:0] b, input logic stopBit, input bit useAlt, input int d);
    logic [9:0] bits;
    bits = {stopBit, b, 1'b0};
    @(negedge clk);
    for (int k = 0; k < 10; k++) begin
      setRx(useAlt, bits[k]);
      repeat (d + 1) @(negedge clk);
    end
    setRx(useAlt, 1'b1);
    repeat (2 * (d + 1) + 4) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (5) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    #1 chk("R1 txd idle", {30'h0, txdMain, txdAlt}, 32'h3);
    peek(2'd0, v); chk("R1 status", v, 32'h0);
    peek(2'd1, v); chk("R1 rx empty", v, 32'hFFFF_FFFF);
    peek(2'd2, v); chk("R1 divisor", v, 32'd88);

    // R5 divisor width
    regWrite(2'd2, 32'hABC1_2345);
    peek(2'd2, v); chk("R5 low 16 bits", v, 32'h0000_2345);
    regWrite(2'd2, 32'hFFFF_FFFF);
    peek(2'd2, v); chk("R5 all ones", v, 32'h0000_FFFF);

    // transmit sweep, divisor 2: all byte values
    regWrite(2'd2, 32'd2);
    for (int i = 0; i < 256; i++) txFrame(i[7:0], 2, 1'b0);

    // divisor 5, relocation toggled, one write during a frame
    regWrite(2'd2, 32'd5);
    for (int i = 0; i < 6; i++) begin
      relocEn = i[0];
      txFrame(8'h5A ^ 8'(i * 37), 5, (i == 3));
    end
    relocEn = 1'b0;

    // receive sweep, divisor 3
    regWrite(2'd2, 32'd3);
    for (int i = 0; i < 256; i++) begin
      rxSend(i[7:0], 1'b1, 1'b0, 3);
      regRead(2'd1, v); chk("R6 received byte", v, {24'h0, i[7:0]});
      if (i % 64 == 0) begin
        regRead(2'd1, v); chk("R7 emptied by read", v, 32'hFFFF_FFFF);
      end
    end

    // R7 other reads do not consume
    rxSend(8'h3C, 1'b1, 1'b0, 3);
    regRead(2'd0, v);
    regRead(2'd2, v);
    regRead(2'd1, v); chk("R7 kept across other reads", v, 32'h3C);

    // R8 overwrite
    rxSend(8'h11, 1'b1, 1'b0, 3);
    rxSend(8'h22, 1'b1, 1'b0, 3);
    regRead(2'd1, v); chk("R8 newest byte kept", v, 32'h22);

    // R9 bad stop bit
    rxSend(8'h77, 1'b0, 1'b0, 3);
    peek(2'd1, v); chk("R9 bad frame dropped", v, 32'hFFFF_FFFF);
    rxSend(8'h78, 1'b1, 1'b0, 3);
    regRead(2'd1, v); chk("R9 recovery", v, 32'h78);
    rxSend(8'h41, 1'b1, 1'b0, 3);
    rxSend(8'h99, 1'b0, 1'b0, 3);
    regRead(2'd1, v); chk("R9 held byte untouched", v, 32'h41);

    // R10 short glitch
    @(negedge clk); rxdMain = 1'b0;
    @(negedge clk); rxdMain = 1'b1;
    repeat (60) @(negedge clk);
    peek(2'd1, v); chk("R10 glitch rejected", v, 32'hFFFF_FFFF);
    rxSend(8'hC4, 1'b1, 1'b0, 3);
    regRead(2'd1, v); chk("R10 next frame ok", v, 32'hC4);

    // R11 relocation on the receive side
    relocEn = 1'b1;
    rxSend(8'h96, 1'b1, 1'b1, 3);
    regRead(2'd1, v); chk("R11 alt pad received", v, 32'h96);
    rxSend(8'h69, 1'b1, 1'b0, 3);
    peek(2'd1, v); chk("R11 default pad ignored", v, 32'hFFFF_FFFF);
    relocEn = 1'b0;
    rxSend(8'h55, 1'b1, 1'b1, 3);
    peek(2'd1, v); chk("R11 alt pad ignored", v, 32'hFFFF_FFFF);
    rxSend(8'hAA, 1'b1, 1'b0, 3);
    regRead(2'd1, v); chk("R11 default pad received", v, 32'hAA);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule